// File: doc/BRIEF.md
# UART Buffer Status and Transmit Watermark Controller

This block sits between a UART's shift engines and its host-side register port. It holds an eight-entry transmit FIFO filled by host writes and drained by the transmit shifter. It also holds an eight-entry receive FIFO filled by the receive shifter and drained by host reads. Next to the two FIFOs it keeps two sticky error flags. One records a host write into a full transmit FIFO. The other records a host read from an empty receive FIFO.

A programmable transmit watermark is compared against the transmit fill level, which produces a "transmit data needed" status. A steering bit sends that status either to a DMA request line or to a transmit interrupt line. The transmit interrupt line is further gated by its own enable. The error flags latch whatever their interrupt enables are set to. Only the shared error interrupt output is gated by those enables.

The host port has a separate write strobe and read strobe, each with its own 2-bit address. It offers four locations: the data window, the flags, the watermark and the fill levels. The flags are cleared by writing a 1 to their bit.

Top module: `uart_bufstat`

## Requirements
- R1: After reset both FIFOs are empty, both error flags are 0, the watermark reads 0 and the need status (FLAGS bit 2) reads 1.
- R2: A write to address 0 pushes `wr_wdata` into the transmit FIFO, which holds at most 8 words. A write while 8 words are held is dropped, and from the next cycle it sets the overflow flag (FLAGS bit 1, address 1).
- R3: A read of address 0 pops the receive FIFO and returns its head on `rd_rdata` in the same cycle. A read of an empty receive FIFO returns the last word popped, leaves the pointers unchanged and sets the underflow flag (FLAGS bit 0).
- R4: Each error flag stays set until a write to address 1 carries a 1 in that flag's bit. Writing a 0 in that bit leaves the flag unchanged.
- R5: When an error event and a write-one-to-clear of the same flag happen in one cycle, the flag is set afterwards.
- R6: `err_irq` is high when the overflow flag is set with `ovf_irq_en` high, or when the underflow flag is set with `unf_irq_en` high. The flags latch whatever the enables are set to.
- R7: The 8-bit watermark at address 2 can be read at any time. A write to it takes effect only while `tx_en` is 0.
- R8: The need status is re-evaluated as (transmit fill level <= watermark) only in a cycle where the transmit fill level changes. A watermark write alone leaves it unchanged.
- R9: With `dma_sel` = 1, `dma_req` follows the need status and `tx_irq` is 0. With `dma_sel` = 0, `tx_irq` = need AND `tx_irq_en`, and `dma_req` is 0.
- R10: `tx_pop` drains the transmit FIFO in write order, with the head shown on `tx_pdata`. A pop of an empty FIFO repeats the last word popped and leaves the FIFO unchanged.
- R11: `rx_push` stores `rx_pdata` unless 8 words are held, in which case the word is dropped. Address 3 reads the receive level in bits 7:4 and the transmit level in bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmitter enabled; locks the watermark |
| dma_sel | input | 1 | Route the need status to DMA instead of the interrupt |
| tx_irq_en | input | 1 | Transmit interrupt enable |
| ovf_irq_en | input | 1 | Overflow interrupt enable |
| unf_irq_en | input | 1 | Underflow interrupt enable |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 2 | Host write address |
| wr_wdata | input | 8 | Host write data |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | 2 | Host read address |
| rd_rdata | output | 8 | Host read data (combinational) |
| tx_pop | input | 1 | Transmit shifter takes one word |
| tx_pdata | output | 8 | Transmit FIFO head |
| rx_push | input | 1 | Receive shifter delivers one word |
| rx_pdata | input | 8 | Received word |
| tx_irq | output | 1 | Transmit data needed interrupt |
| dma_req | output | 1 | Transmit data needed DMA request |
| err_irq | output | 1 | Gated error interrupt |

## Verification
Read data and the FIFO heads are combinational, so each is sampled in the cycle of the strobe, before the edge that pops. Flags, the watermark, the levels and the need status change at the first clock edge after the write, push or pop. Every stimulus is applied on a falling edge and held for exactly one rising edge, and these results are read back on the next falling edge. `tx_irq`, `dma_req` and `err_irq` are combinational from registered state and the enable inputs. They are checked one time step after an enable changes, and no clock edge is needed for that.

// File: rtl/bufstat_pkg.sv
package bufstat_pkg;
  // Host register addresses
  localparam logic [1:0] ADR_DATA  = 2'd0;
  localparam logic [1:0] ADR_FLAGS = 2'd1;
  localparam logic [1:0] ADR_WMARK = 2'd2;
  localparam logic [1:0] ADR_LEVEL = 2'd3;
  // Flag bit positions inside the FLAGS word
  localparam int FLG_UNF = 0;
  localparam int FLG_OVF = 1;
  localparam int FLG_NEED = 2;
  localparam int NFLAGS = 2;
endpackage

// File: rtl/bufstat_fifo.sv
module bufstat_fifo #(
  parameter int DW = 8,
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] pdata,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cnt_nxt
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] last_q, last_d;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    push_ok  = push & (cnt_q != CW'(DEPTH));
    pop_ok   = pop & (cnt_q != '0);
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    last_d   = last_q;
    if (push_ok) wr_ptr_d = bump(wr_ptr_q);
    if (pop_ok) begin
      rd_ptr_d = bump(rd_ptr_q);
      last_d   = mem[rd_ptr_q];
    end
    cnt_d = cnt_q + CW'(push_ok) - CW'(pop_ok);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      last_q   <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
      last_q   <= last_d;
    end
  end

  // Storage array carries no reset
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr_q] <= pdata;
  end

  assign head    = (cnt_q == '0) ? last_q : mem[rd_ptr_q];
  assign cnt     = cnt_q;
  assign cnt_nxt = cnt_d;
endmodule

// File: rtl/bufstat_sticky.sv
module bufstat_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  logic q_q, q_d;

  // Set has priority over a simultaneous clear
  always_comb q_d = set | (q_q & ~clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= 1'b0;
    else        q_q <= q_d;
  end

  assign q = q_q;
endmodule

// File: rtl/bufstat_txreq.sv
module bufstat_txreq #(
  parameter int WMW = 8,
  parameter int CW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wm_we,
  input  logic [WMW-1:0] wm_wdata,
  input  logic           tx_en,
  input  logic           lvl_chg,
  input  logic [CW-1:0]  lvl_nxt,
  input  logic           dma_sel,
  input  logic           tx_irq_en,
  output logic [WMW-1:0] wm,
  output logic           need,
  output logic           tx_irq,
  output logic           dma_req
);
  localparam int CMPW = (WMW > CW) ? WMW : CW;

  logic [WMW-1:0] wm_q, wm_d;
  logic           need_q, need_d;

  always_comb begin
    wm_d   = (wm_we & ~tx_en) ? wm_wdata : wm_q;
    // Only a fill-level change re-evaluates the status
    need_d = lvl_chg ? (CMPW'(lvl_nxt) <= CMPW'(wm_q)) : need_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wm_q   <= '0;
      need_q <= 1'b1;
    end else begin
      wm_q   <= wm_d;
      need_q <= need_d;
    end
  end

  assign wm      = wm_q;
  assign need    = need_q;
  assign dma_req = need_q & dma_sel;
  assign tx_irq  = need_q & ~dma_sel & tx_irq_en;
endmodule

// File: rtl/uart_bufstat.sv
module uart_bufstat
  import bufstat_pkg::*;
#(
  parameter int DW = 8,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_en,
  input  logic          dma_sel,
  input  logic          tx_irq_en,
  input  logic          ovf_irq_en,
  input  logic          unf_irq_en,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [DW-1:0] wr_wdata,
  input  logic          rd_en,
  input  logic [1:0]    rd_addr,
  output logic [DW-1:0] rd_rdata,
  input  logic          tx_pop,
  output logic [DW-1:0] tx_pdata,
  input  logic          rx_push,
  input  logic [DW-1:0] rx_pdata,
  output logic          tx_irq,
  output logic          dma_req,
  output logic          err_irq
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int LVW = DW / 2;

  logic              wr_data, wr_flags, wr_wm, rd_data;
  logic [CW-1:0]     tx_cnt, tx_cnt_nxt, rx_cnt, rx_cnt_nxt_unused;
  logic [DW-1:0]     rx_head;
  logic              tx_full, rx_empty;
  logic [NFLAGS-1:0] flag_set, flag_clr, sticky;
  logic [DW-1:0]     wm_q;
  logic              need_q;

  always_comb begin
    wr_data  = wr_en & (wr_addr == ADR_DATA);
    wr_flags = wr_en & (wr_addr == ADR_FLAGS);
    wr_wm    = wr_en & (wr_addr == ADR_WMARK);
    rd_data  = rd_en & (rd_addr == ADR_DATA);
    tx_full  = (tx_cnt == CW'(DEPTH));
    rx_empty = (rx_cnt == '0);
  end

  bufstat_fifo #(.DW(DW), .DEPTH(DEPTH)) u_txf (
    .clk(clk), .rst_n(rst_n),
    .push(wr_data), .pdata(wr_wdata), .pop(tx_pop),
    .head(tx_pdata), .cnt(tx_cnt), .cnt_nxt(tx_cnt_nxt)
  );

  bufstat_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rxf (
    .clk(clk), .rst_n(rst_n),
    .push(rx_push), .pdata(rx_pdata), .pop(rd_data),
    .head(rx_head), .cnt(rx_cnt), .cnt_nxt(rx_cnt_nxt_unused)
  );

  always_comb begin
    flag_set          = '0;
    flag_set[FLG_UNF] = rd_data & rx_empty;
    flag_set[FLG_OVF] = wr_data & tx_full;
    flag_clr          = {NFLAGS{wr_flags}} & wr_wdata[NFLAGS-1:0];
  end

  for (genvar g = 0; g < NFLAGS; g++) begin : g_flag
    bufstat_sticky u_flag (
      .clk(clk), .rst_n(rst_n),
      .set(flag_set[g]), .clr(flag_clr[g]), .q(sticky[g])
    );
  end

  bufstat_txreq #(.WMW(DW), .CW(CW)) u_req (
    .clk(clk), .rst_n(rst_n),
    .wm_we(wr_wm), .wm_wdata(wr_wdata), .tx_en(tx_en),
    .lvl_chg(tx_cnt_nxt != tx_cnt), .lvl_nxt(tx_cnt_nxt),
    .dma_sel(dma_sel), .tx_irq_en(tx_irq_en),
    .wm(wm_q), .need(need_q), .tx_irq(tx_irq), .dma_req(dma_req)
  );

  assign err_irq = (sticky[FLG_OVF] & ovf_irq_en) | (sticky[FLG_UNF] & unf_irq_en);

  always_comb begin
    unique case (rd_addr)
      ADR_DATA:  rd_rdata = rx_head;
      ADR_FLAGS: rd_rdata = DW'({need_q, sticky});
      ADR_WMARK: rd_rdata = wm_q;
      default:   rd_rdata = {LVW'(rx_cnt), LVW'(tx_cnt)};
    endcase
  end
endmodule

// File: rtl/bufstat_chk.sv
module bufstat_chk
  import bufstat_pkg::*;
#(
  parameter int DW = 8,
  parameter int DEPTH = 8,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_en,
  input logic          dma_sel,
  input logic          ovf_irq_en,
  input logic          unf_irq_en,
  input logic          wr_en,
  input logic [1:0]    wr_addr,
  input logic [DW-1:0] wr_wdata,
  input logic          rd_en,
  input logic [1:0]    rd_addr,
  input logic          tx_irq,
  input logic          dma_req,
  input logic          err_irq,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt,
  input logic [1:0]    flags,
  input logic [DW-1:0] wm_q,
  input logic          need_q
);
  logic wdat, wflg, rdat;
  assign wdat = wr_en && (wr_addr == ADR_DATA);
  assign wflg = wr_en && (wr_addr == ADR_FLAGS);
  assign rdat = rd_en && (rd_addr == ADR_DATA);

  a_r2_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt <= CW'(DEPTH)) && (rx_cnt <= CW'(DEPTH)));

  a_r2_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wdat && tx_cnt == CW'(DEPTH)) |=> flags[FLG_OVF]);

  a_r3_unf_set: assert property (@(posedge clk) disable iff (!rst_n)
    (rdat && rx_cnt == '0) |=> flags[FLG_UNF]);

  a_r3_empty_read_holds_level: assert property (@(posedge clk) disable iff (!rst_n)
    (rdat && rx_cnt == '0) |=> rx_cnt <= CW'(1));

  a_r4_ovf_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[FLG_OVF] && !(wflg && wr_wdata[FLG_OVF])) |=> flags[FLG_OVF]);

  a_r4_unf_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[FLG_UNF] && !(wflg && wr_wdata[FLG_UNF])) |=> flags[FLG_UNF]);

  a_r4_ovf_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (!flags[FLG_OVF] && !wdat) |=> !flags[FLG_OVF]);

  a_r5_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rdat && rx_cnt == '0 && wflg && wr_wdata[FLG_UNF]) |=> flags[FLG_UNF]);

  a_r6_err_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovf_irq_en && !unf_irq_en) |-> !err_irq);

  a_r7_wm_locked: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en |=> $stable(wm_q));

  a_r8_need_follows_level: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(need_q) |-> !$stable(tx_cnt));

  a_r9_dma_excludes_irq: assert property (@(posedge clk) disable iff (!rst_n)
    dma_sel |-> !tx_irq);

  a_r9_irq_excludes_dma: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_sel |-> !dma_req);
endmodule

bind uart_bufstat bufstat_chk #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .dma_sel(dma_sel),
  .ovf_irq_en(ovf_irq_en), .unf_irq_en(unf_irq_en),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_wdata(wr_wdata),
  .rd_en(rd_en), .rd_addr(rd_addr),
  .tx_irq(tx_irq), .dma_req(dma_req), .err_irq(err_irq),
  .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .flags(sticky),
  .wm_q(wm_q), .need_q(need_q)
);

// File: tb/sim_uart_bufstat.sv
module sim_uart_bufstat;
  import bufstat_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tx_en, dma_sel, tx_irq_en, ovf_irq_en, unf_irq_en;
  logic       wr_en, rd_en, tx_pop, rx_push;
  logic [1:0] wr_addr, rd_addr;
  logic [7:0] wr_wdata, rd_rdata, tx_pdata, rx_pdata;
  logic       tx_irq, dma_req, err_irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  uart_bufstat u0 (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .dma_sel(dma_sel),
    .tx_irq_en(tx_irq_en), .ovf_irq_en(ovf_irq_en), .unf_irq_en(unf_irq_en),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_wdata(wr_wdata),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_rdata(rd_rdata),
    .tx_pop(tx_pop), .tx_pdata(tx_pdata),
    .rx_push(rx_push), .rx_pdata(rx_pdata),
    .tx_irq(tx_irq), .dma_req(dma_req), .err_irq(err_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // All bus tasks start and end on a falling edge
  task automatic wreg(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rreg(input logic [1:0] a, output logic [7:0] d);
    rd_en = 1'b1; rd_addr = a;
    #1 d = rd_rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic txpop(output logic [7:0] d);
    tx_pop = 1'b1;
    #1 d = tx_pdata;
    @(negedge clk);
    tx_pop = 1'b0;
  endtask

  task automatic rxpush(input logic [7:0] d);
    rx_push = 1'b1; rx_pdata = d;
    @(negedge clk);
    rx_push = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rreg(ADR_FLAGS, d); chk("R1 flags after reset", d, 8'h04);
    rreg(ADR_WMARK, d); chk("R1 watermark after reset", d, 8'h00);
    rreg(ADR_LEVEL, d); chk("R1 levels after reset", d, 8'h00);
    chk("R1 err_irq after reset", err_irq, 1'b0);
    chk("R1 dma_req after reset", dma_req, 1'b0);
  endtask

  task automatic t_tx_order_ovf;
    logic [7:0] d;
    for (int i = 0; i < 8; i++) wreg(ADR_DATA, 8'hA0 + 8'(i));
    rreg(ADR_LEVEL, d); chk("R11 tx level full", d, 8'h08);
    rreg(ADR_FLAGS, d); chk("R2 no overflow at capacity", d[1], 1'b0);
    wreg(ADR_DATA, 8'hEE);
    rreg(ADR_FLAGS, d); chk("R2 overflow flag", d[1], 1'b1);
    rreg(ADR_LEVEL, d); chk("R2 level after dropped write", d, 8'h08);
    for (int i = 0; i < 8; i++) begin
      txpop(d); chk("R10 tx order", d, 8'hA0 + 8'(i));
    end
    txpop(d); chk("R10 empty pop repeats last", d, 8'hA7);
    rreg(ADR_LEVEL, d); chk("R10 tx level empty", d, 8'h00);
  endtask

  task automatic t_w1c;
    logic [7:0] d;
    wreg(ADR_FLAGS, 8'h00);
    rreg(ADR_FLAGS, d); chk("R4 write zero keeps flag", d[1:0], 2'b10);
    wreg(ADR_FLAGS, 8'h01);
    rreg(ADR_FLAGS, d); chk("R4 other bit keeps flag", d[1:0], 2'b10);
    wreg(ADR_FLAGS, 8'h02);
    rreg(ADR_FLAGS, d); chk("R4 write one clears", d[1:0], 2'b00);
  endtask

  task automatic t_rx_underflow;
    logic [7:0] d;
    rxpush(8'h11); rxpush(8'h22);
    rreg(ADR_DATA, d); chk("R3 rx first", d, 8'h11);
    rreg(ADR_DATA, d); chk("R3 rx second", d, 8'h22);
    rreg(ADR_DATA, d); chk("R3 empty read repeats last", d, 8'h22);
    rreg(ADR_FLAGS, d); chk("R3 underflow flag", d[0], 1'b1);
    rreg(ADR_LEVEL, d); chk("R3 rx level stays 0", d, 8'h00);
    rxpush(8'h33);
    rreg(ADR_DATA, d); chk("R3 pointers unmoved", d, 8'h33);
    wreg(ADR_FLAGS, 8'h01);
    rreg(ADR_FLAGS, d); chk("R4 underflow cleared", d[1:0], 2'b00);
  endtask

  task automatic t_rx_drop;
    logic [7:0] d;
    for (int i = 0; i < 9; i++) rxpush(8'h40 + 8'(i));
    rreg(ADR_LEVEL, d); chk("R11 rx level capped", d, 8'h80);
    for (int i = 0; i < 8; i++) begin
      rreg(ADR_DATA, d); chk("R11 rx order, ninth dropped", d, 8'h40 + 8'(i));
    end
    rreg(ADR_FLAGS, d); chk("R11 no underflow", d[0], 1'b0);
  endtask

  task automatic t_irq_gate;
    logic [7:0] d;
    rreg(ADR_DATA, d);
    rreg(ADR_FLAGS, d); chk("R6 flag latches while disabled", d[0], 1'b1);
    chk("R6 err_irq gated off", err_irq, 1'b0);
    unf_irq_en = 1'b1;
    #1 chk("R6 err_irq on enable", err_irq, 1'b1);
    unf_irq_en = 1'b0; ovf_irq_en = 1'b1;
    #1 chk("R6 other enable alone", err_irq, 1'b0);
    ovf_irq_en = 1'b0;
    @(negedge clk);
    wreg(ADR_FLAGS, 8'h01);
  endtask

  task automatic t_same_cycle;
    logic [7:0] d;
    rd_en = 1'b1; rd_addr = ADR_DATA;
    wr_en = 1'b1; wr_addr = ADR_FLAGS; wr_wdata = 8'h01;
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    rreg(ADR_FLAGS, d); chk("R5 set wins over clear", d[0], 1'b1);
    wreg(ADR_FLAGS, 8'h01);
    rreg(ADR_FLAGS, d); chk("R5 later clear works", d[0], 1'b0);
  endtask

  task automatic t_wm_lock;
    logic [7:0] d;
    tx_en = 1'b1;
    wreg(ADR_WMARK, 8'h05);
    rreg(ADR_WMARK, d); chk("R7 write ignored while enabled", d, 8'h00);
    tx_en = 1'b0;
    wreg(ADR_WMARK, 8'hA5);
    rreg(ADR_WMARK, d); chk("R7 write accepted", d, 8'hA5);
    wreg(ADR_WMARK, 8'h00);
    rreg(ADR_WMARK, d); chk("R7 write back zero", d, 8'h00);
  endtask

  task automatic t_need;
    logic [7:0] d;
    rreg(ADR_FLAGS, d); chk("R8 need with empty fifo", d[2], 1'b1);
    wreg(ADR_DATA, 8'h01);
    rreg(ADR_FLAGS, d); chk("R8 level 1 above mark 0", d[2], 1'b0);
    wreg(ADR_WMARK, 8'h03);
    rreg(ADR_FLAGS, d); chk("R8 mark write no re-eval", d[2], 1'b0);
    wreg(ADR_DATA, 8'h02);
    rreg(ADR_FLAGS, d); chk("R8 level 2 within mark 3", d[2], 1'b1);
    wreg(ADR_WMARK, 8'h00);
    rreg(ADR_FLAGS, d); chk("R8 lowering mark keeps status", d[2], 1'b1);
    txpop(d);
    rreg(ADR_FLAGS, d); chk("R8 level 1 above mark 0 again", d[2], 1'b0);
    txpop(d);
    rreg(ADR_FLAGS, d); chk("R8 empty within mark", d[2], 1'b1);
  endtask

  task automatic t_steer;
    logic [7:0] d;
    dma_sel = 1'b1; tx_irq_en = 1'b1;
    #1 chk("R9 dma_req on need", dma_req, 1'b1);
    chk("R9 tx_irq off in dma mode", tx_irq, 1'b0);
    dma_sel = 1'b0;
    #1 chk("R9 tx_irq on need", tx_irq, 1'b1);
    chk("R9 dma_req off in irq mode", dma_req, 1'b0);
    tx_irq_en = 1'b0;
    #1 chk("R9 tx_irq gated by enable", tx_irq, 1'b0);
    @(negedge clk);
    wreg(ADR_DATA, 8'h5A);
    dma_sel = 1'b1;
    #1 chk("R9 dma_req drops without need", dma_req, 1'b0);
    dma_sel = 1'b0;
    @(negedge clk);
    txpop(d);
  endtask

  initial begin
    rst_n = 1'b0; tx_en = 1'b0; dma_sel = 1'b0; tx_irq_en = 1'b0;
    ovf_irq_en = 1'b0; unf_irq_en = 1'b0;
    wr_en = 1'b0; rd_en = 1'b0; tx_pop = 1'b0; rx_push = 1'b0;
    wr_addr = '0; rd_addr = '0; wr_wdata = '0; rx_pdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_tx_order_ovf();
    t_w1c();
    t_rx_underflow();
    t_rx_drop();
    t_irq_gate();
    t_same_cycle();
    t_wm_lock();
    t_need();
    t_steer();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule